// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Slave

This block is a synthesizable model of the command side of a small serial EEPROM that holds 64 words of 16 bits. A host drives a chip select, a serial clock and a serial data input. The block answers on one data output, which is modelled as a data bit plus an output-enable. All serial pins are sampled on the system clock, and the block acts on serial-clock rising edges that it detects.

A command is a start bit of 1, then a 2-bit opcode, then a 6-bit address. The block accepts four commands: enable writes, disable writes, write a word, and read a word. A write-enable latch guards every write. When a write command is complete, the word is programmed after chip select falls. Programming takes a parameterised number of system clocks and is modelled by a counter. If the host raises chip select during that time, the output reports busy or ready. The storage is a register array.

Top module: `ee_serial_slave`

## Requirements
- R1: After reset the output-enable is low, the array reads as all zeros and the write-enable latch is clear, so a write command does not start programming.
- R2: The command 1, 00, 11xxxx sets the write-enable latch. The latch stays set through other commands until the command 1, 00, 00xxxx clears it or reset is asserted.
- R3: The read command 1, 10, A5..A0 raises the output-enable from the last address bit onward and drives a 0. Each later serial-clock rising edge then drives the next bit of the word, D15 first. Reads work whether the latch is set or clear.
- R4: The write command 1, 01, A5..A0, D15..D0 has 25 bits, each field MSB first. It starts programming when chip select falls only if all 25 bits arrived and the latch is set.
- R5: Programming stays busy for exactly PROG_CYCLES system clocks after the clock that sees chip select low. The word is stored when it ends and can be read back.
- R6: If chip select is high after programming started, the output is enabled and shows 0 while busy and 1 once done. A new start bit or a later chip-select fall ends this status display.
- R7: While busy, serial-clock and data-in activity is ignored and no command is accepted.
- R8: The output-enable is low while command, address or data bits are being shifted in, and whenever chip select is low.
- R9: Zeros on data in before the first 1 are skipped while the block looks for the start bit.
- R10: Chip select going low at any point abandons a partly received command. A write with fewer than 16 data bits programs nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, acts like power-up |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, acted on at rising edges |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out value |
| dout_oe | output | 1 | Output-enable for dout; low means high impedance |

## Verification
The hardest case to reach is a host that raises chip select during the programming window and clocks a full read command into the block while it still shows busy. The stimulus ends a write and counts system clocks from the chip-select fall. It raises chip select a few clocks later and shifts nine command bits well inside the window. The bench then checks that the status stays busy, turns to ready at exactly the expected clock, and is never replaced by read data. A behavioural model run alongside compares the output pair on every clock, so the busy length and the read-bit timing are pinned to the cycle.

// File: rtl/ee_pkg.sv
package ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } ee_state_t;

  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [1:0] SUB_ENABLE  = 2'b11;
  localparam logic [1:0] SUB_DISABLE = 2'b00;

  function automatic logic is_enable_cmd(logic [1:0] op, logic [1:0] sub);
    return (op == OP_MISC) && (sub == SUB_ENABLE);
  endfunction

  function automatic logic is_disable_cmd(logic [1:0] op, logic [1:0] sub);
    return (op == OP_MISC) && (sub == SUB_DISABLE);
  endfunction

  function automatic ee_state_t state_after_addr(logic [1:0] op);
    case (op)
      OP_WRITE: return ST_DATA;
      OP_READ:  return ST_READ;
      default:  return ST_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/ee_edge_pulse.sv
module ee_edge_pulse #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic pulse
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sig;
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = sig & ~prev;
    end else begin : g_fall
      assign pulse = ~sig & prev;
    end
  endgenerate

endmodule

// File: rtl/ee_cmd_decoder.sv
module ee_cmd_decoder
  import ee_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sclk_rise,
  input  logic              sdi,
  input  logic              busy,
  output logic              start_seen,
  output logic              wen_set,
  output logic              wen_clr,
  output logic              rd_start,
  output logic              in_read,
  output logic              write_armed,
  output logic [ADDR_W-1:0] addr_full,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata
);

  localparam int LONGEST = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  ee_state_t       st;
  logic [1:0]      op_q;
  logic [CNT_W-1:0] cnt;
  logic            go;
  logic            op_last;
  logic            addr_last;
  logic            data_last;

  // a serial clock edge that the decoder is allowed to act on
  assign go        = sel & sclk_rise & ~busy;
  assign op_last   = go && (st == ST_OPC)  && (cnt == CNT_W'(1));
  assign addr_last = go && (st == ST_ADDR) && (cnt == CNT_W'(ADDR_W - 1));
  assign data_last = go && (st == ST_DATA) && (cnt == CNT_W'(DATA_W - 1));
  assign addr_full = {addr_q[ADDR_W-2:0], sdi};

  assign start_seen  = go && (st == ST_IDLE) && sdi;
  assign wen_set     = addr_last && is_enable_cmd(op_q, addr_full[ADDR_W-1 -: 2]);
  assign wen_clr     = addr_last && is_disable_cmd(op_q, addr_full[ADDR_W-1 -: 2]);
  assign rd_start    = addr_last && (op_q == OP_READ);
  assign in_read     = (st == ST_READ);
  assign write_armed = (st == ST_HOLD) && (op_q == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op_q   <= '0;
      cnt    <= '0;
      addr_q <= '0;
      wdata  <= '0;
    end else if (!sel) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (go) begin
      case (st)
        ST_IDLE: begin
          if (sdi) begin
            st  <= ST_OPC;
            cnt <= '0;
          end
        end
        ST_OPC: begin
          op_q <= {op_q[0], sdi};
          if (op_last) begin
            st  <= ST_ADDR;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ADDR: begin
          addr_q <= addr_full;
          if (addr_last) begin
            st  <= state_after_addr(op_q);
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          wdata <= {wdata[DATA_W-2:0], sdi};
          if (data_last) begin
            st  <= ST_HOLD;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: a deselected device always returns to hunting for a start bit
  assert_idle_after_deselect_R10: assert property (
    @(posedge clk) disable iff (!rst_n) !sel |=> (st == ST_IDLE));

  // R7: while programming, the decoder state does not move
  assert_frozen_when_busy_R7: assert property (
    @(posedge clk) disable iff (!rst_n) (busy && sel) |=> $stable(st));

endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES);
    end else if (busy) begin
      if (done) busy <= 1'b0;
      cnt <= cnt - 1'b1;
    end
  end

  // R5: a new programming cycle only starts from idle
  assert_start_from_idle_R5: assert property (
    @(posedge clk) disable iff (!rst_n) start |-> !busy);

  // R5: starting always shows busy on the next cycle
  assert_busy_follows_start_R5: assert property (
    @(posedge clk) disable iff (!rst_n) start |=> busy);

endmodule

// File: rtl/ee_serial_slave.sv
module ee_serial_slave
  import ee_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic din,
  output logic dout,
  output logic dout_oe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic              sck_rise;
  logic              cs_fall;
  logic              start_seen;
  logic              wen_set;
  logic              wen_clr;
  logic              rd_start;
  logic              in_read;
  logic              write_armed;
  logic [ADDR_W-1:0] addr_full;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata;
  logic              busy;
  logic              prog_done;
  logic              prog_start;

  logic              wen_q;
  logic              status_q;
  logic [DATA_W-1:0] rd_shift;
  logic              rd_bit;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data;
  logic [DATA_W-1:0] mem [DEPTH];

  ee_edge_pulse #(.RISING(1'b1)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .sig(sck), .pulse(sck_rise));

  ee_edge_pulse #(.RISING(1'b0)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .sig(cs), .pulse(cs_fall));

  ee_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (cs),
    .sclk_rise  (sck_rise),
    .sdi        (din),
    .busy       (busy),
    .start_seen (start_seen),
    .wen_set    (wen_set),
    .wen_clr    (wen_clr),
    .rd_start   (rd_start),
    .in_read    (in_read),
    .write_armed(write_armed),
    .addr_full  (addr_full),
    .addr_q     (addr_q),
    .wdata      (wdata)
  );

  ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(prog_start),
    .busy (busy),
    .done (prog_done)
  );

  assign prog_start = cs_fall & write_armed & wen_q;

  // write-enable latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wen_q <= 1'b0;
    else if (wen_set) wen_q <= 1'b1;
    else if (wen_clr) wen_q <= 1'b0;
  end

  // busy/ready display window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  status_q <= 1'b0;
    else if (prog_start)         status_q <= 1'b1;
    else if (start_seen)         status_q <= 1'b0;
    else if (cs_fall && !busy)   status_q <= 1'b0;
  end

  // programming target held for the whole cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (prog_start) begin
      prog_addr <= addr_q;
      prog_data <= wdata;
    end
  end

  // storage array, committed at the end of programming
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (prog_done) begin
      mem[prog_addr] <= prog_data;
    end
  end

  // read shifter: dummy zero first, then MSB-first word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_shift <= '0;
      rd_bit   <= 1'b0;
    end else if (rd_start) begin
      rd_shift <= mem[addr_full];
      rd_bit   <= 1'b0;
    end else if (in_read && cs && sck_rise) begin
      rd_bit   <= rd_shift[DATA_W-1];
      rd_shift <= {rd_shift[DATA_W-2:0], 1'b0};
    end
  end

  assign dout_oe = cs & (in_read | status_q);
  assign dout    = in_read ? rd_bit : ~busy;

  // R2: the latch only drops on a disable command
  assert_wen_sticky_R2: assert property (
    @(posedge clk) disable iff (!rst_n) (wen_q && !wen_clr) |=> wen_q);

  // R4: programming never begins with the latch clear
  assert_prog_needs_wen_R4: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wen_q));

  // R5: the end of the timed cycle stores the held word
  assert_commit_on_done_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
      prog_done |=> (mem[prog_addr] == $past(prog_data)));

  // R7: no start bit is taken while programming
  assert_no_start_busy_R7: assert property (
    @(posedge clk) disable iff (!rst_n) busy |-> !start_seen);

endmodule

// File: tb/tb_ee_serial_slave.sv
module tb_ee_serial_slave;

  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sck = 1'b0;
  logic din = 1'b0;
  wire  dout;
  wire  dout_oe;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_serial_slave #(.ADDR_W(6), .DATA_W(16), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .din(din),
    .dout(dout), .dout_oe(dout_oe));

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every clock
  int  m_mem [64];
  bit  m_wen, m_status, cur, p_sck, p_cs, exp_oe, exp_do;
  int  m_left, ph, nbits, op, ad, hdr, wd, pa, pd;
  bit  rdq [$];

  always @(posedge clk) begin
    bit rise, csf, bsy;
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_wen = 0; m_status = 0; m_left = 0; ph = 0; cur = 0;
      rdq.delete(); p_sck = 0; p_cs = 0;
    end else begin
      rise = sck && !p_sck;
      csf  = p_cs && !cs;
      bsy  = (m_left > 0);
      if (bsy) begin
        m_left--;
        if (m_left == 0) m_mem[pa] = pd;
      end
      if (!cs) begin
        if (csf) begin
          if (ph == 4 && op == 1 && m_wen) begin
            m_left = PROG; pa = ad; pd = wd; m_status = 1;
          end else if (!bsy) m_status = 0;
        end
        ph = 0; rdq.delete();
      end else if (rise && !bsy) begin
        case (ph)
          0: if (din) begin ph = 1; nbits = 0; hdr = 0; m_status = 0; end
          1: begin
            hdr = (hdr << 1) | int'(din); nbits++;
            if (nbits == 8) begin
              op = (hdr >> 6) & 3; ad = hdr & 63;
              if (op == 0) begin
                if ((ad >> 4) == 3) m_wen = 1;
                if ((ad >> 4) == 0) m_wen = 0;
                ph = 4;
              end else if (op == 1) begin
                ph = 2; nbits = 0; wd = 0;
              end else if (op == 2) begin
                rdq.delete();
                for (int b = 15; b >= 0; b--) rdq.push_back(m_mem[ad][b]);
                cur = 0; ph = 3;
              end else ph = 4;
            end
          end
          2: begin
            wd = ((wd << 1) | int'(din)) & 16'hFFFF; nbits++;
            if (nbits == 16) ph = 4;
          end
          3: cur = (rdq.size() > 0) ? rdq.pop_front() : 1'b0;
          default: ;
        endcase
      end
      p_sck = sck; p_cs = cs;
    end
    exp_oe = cs && (ph == 3 || m_status);
    exp_do = (ph == 3) ? cur : (m_left == 0);
    #(CLK_PERIOD/4);
    if (rst_n)
      chk(dout_oe == exp_oe && (!exp_oe || dout == exp_do),
          "R3,R6,R8 cycle model", {dout_oe, dout}, {exp_oe, exp_do});
  end

  task automatic sk(bit b);
    din = b; sck = 1'b1; @(negedge clk);
    sck = 1'b0; @(negedge clk);
  endtask

  task automatic send(int v, int n);
    for (int i = n - 1; i >= 0; i--) sk(v[i]);
  endtask

  task automatic cs_up;
    cs = 1'b1; @(negedge clk);
  endtask

  task automatic cs_down;
    cs = 1'b0; din = 1'b0; @(negedge clk); @(negedge clk);
  endtask

  // expects chip select high and the start bit already sent
  task automatic read_body(int a, output int d);
    send(2, 2);
    chk(dout_oe == 1'b0, "R8 oe low during header", dout_oe, 0);
    send(a, 6);
    chk(dout_oe == 1'b1 && dout == 1'b0, "R3 dummy zero", {dout_oe, dout}, 2);
    d = 0;
    for (int i = 0; i < 16; i++) begin
      sk(1'b0);
      d = (d << 1) | int'(dout);
    end
    cs_down;
  endtask

  task automatic read_word(int a, output int d);
    cs_up; sk(1'b1); read_body(a, d);
  endtask

  // leaves chip select low, one negedge after the fall
  task automatic write_word(int a, int d);
    cs_up; send(1, 1); send(1, 2); send(a, 6); send(d, 16);
    cs = 1'b0; din = 1'b0; @(negedge clk);
  endtask

  task automatic misc_cmd(int sub);
    cs_up; send(1, 1); send(0, 2); send((sub << 4) | 5, 6); cs_down;
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout_oe == 1'b0, "R1 oe low after reset", dout_oe, 0);

    // R1: write before any enable is ignored
    write_word(5, 16'hA5C3);
    @(negedge clk); cs = 1'b1; repeat (3) @(negedge clk);
    chk(dout_oe == 1'b0, "R1 R4 no status without latch", dout_oe, 0);
    cs_down;
    read_word(5, d);
    chk(d == 0, "R1 write ignored", d, 0);

    // R9: leading zeros before an enable command
    cs_up; send(0, 3); send(1, 1); send(0, 2); send(6'h35, 6); cs_down;

    // R4 R5 R6: timed programming with status
    write_word(5, 16'hA5C3);
    @(negedge clk); cs = 1'b1;
    repeat (PROG - 4) @(negedge clk);
    chk(dout_oe == 1'b1 && dout == 1'b0, "R6 busy shown", {dout_oe, dout}, 2);
    repeat (3) @(negedge clk);
    chk(dout_oe == 1'b1 && dout == 1'b1, "R5 R6 R9 ready after window", {dout_oe, dout}, 3);
    sk(1'b1);
    chk(dout_oe == 1'b0, "R6 start bit ends status", dout_oe, 0);
    read_body(5, d);
    chk(d == 16'hA5C3, "R3 R4 R5 readback", d, 16'hA5C3);

    // R7: command clocked in while busy is dropped
    write_word(6, 16'h1234);
    @(negedge clk); cs = 1'b1;
    send(1, 1); send(2, 2); send(5, 6);
    chk(dout_oe == 1'b1 && dout == 1'b0, "R7 still busy status", {dout_oe, dout}, 2);
    repeat (PROG) @(negedge clk);
    chk(dout_oe == 1'b1 && dout == 1'b1, "R7 no command taken", {dout_oe, dout}, 3);
    cs_down;
    read_word(6, d);
    chk(d == 16'h1234, "R5 second word", d, 16'h1234);

    // R10: write cut short
    cs_up; send(1, 1); send(1, 2); send(7, 6); send(8'hFF, 8); cs_down;
    cs_up; repeat (2) @(negedge clk);
    chk(dout_oe == 1'b0, "R10 no programming after abort", dout_oe, 0);
    cs_down;
    read_word(7, d);
    chk(d == 0, "R10 word untouched", d, 0);

    // R2: disable blocks writes, reads still work
    misc_cmd(0);
    write_word(9, 16'h0F0F);
    @(negedge clk); cs = 1'b1; repeat (3) @(negedge clk);
    chk(dout_oe == 1'b0, "R2 disable blocks write", dout_oe, 0);
    cs_down;
    read_word(9, d);
    chk(d == 0, "R2 R3 read while disabled", d, 0);
    read_word(6, d);
    chk(d == 16'h1234, "R3 read with latch clear", d, 16'h1234);

    // R2: latch survives a read
    misc_cmd(3);
    read_word(5, d);
    write_word(10, 16'hBEEF);
    repeat (PROG + 4) @(negedge clk);
    read_word(10, d);
    chk(d == 16'hBEEF, "R2 latch kept across read", d, 16'hBEEF);

    // R1: reset clears latch and array
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    write_word(11, 16'h5555);
    repeat (PROG + 4) @(negedge clk);
    read_word(11, d);
    chk(d == 0, "R1 latch cleared by reset", d, 0);
    read_word(10, d);
    chk(d == 0, "R1 array cleared by reset", d, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule